// File: doc/BRIEF.md
# Residue-Checked Adder/Subtractor

This block adds or subtracts two unsigned binary operands. Each operand arrives with a separate check residue taken modulo A = 2^a − 1. The main path forms the result modulo 2^W. A separate check path predicts the residue of that result from the two input residues alone. A third unit folds the delivered result down to a residue modulo A, and a comparator raises an error flag whenever the folded residue and the predicted residue differ. This exposes a fault in the main adder, or a corrupted operand residue, in the same cycle that the result is delivered.

Because A has the form 2^a − 1, every reduction is done by summing a-bit slices with end-around carry, with no divider anywhere. A carry out of the main adder, or a borrow on subtraction, wraps the main result by 2^W. The check path therefore applies the residue of 2^W so that a wrap never raises a false alarm.

A parameter selects whether residues are carried plainly or bitwise inverted. A test input flips one selected bit of the main sum so that the detection logic can be exercised. The block has one cycle of latency, with a valid flag on the input side and a matching flag on the output side.

Top module: `resck_adder`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `result` holds `op_x + op_y` modulo 2^DATA_W when `sub_op` = 0, and `op_x − op_y` modulo 2^DATA_W when `sub_op` = 1, provided fault injection is off.
- R2: `out_valid` equals `in_valid` delayed by one clock. Reset clears `out_valid`, `err`, `result` and `result_chk` to zero. `result` and `result_chk` hold their values through cycles without a transaction.
- R3: `result_chk` carries the predicted residue P in canonical form (0 to A−1, never the all-ones pattern). P is computed from the input residues as dx + dy, or dx − dy when subtracting, plus the wrap correction of R4, all modulo A = 2^RES_A − 1. P does not depend on the value of the main sum.
- R4: When the main adder wraps, the prediction is corrected by the residue of 2^DATA_W, which is 2^(DATA_W mod RES_A). This residue is subtracted when an add carries out and added when a subtract borrows (op_x < op_y). As a result, operands with correct residues never raise `err`, whatever the carry or borrow.
- R5: `err` is 1 exactly when `out_valid` is 1 and `result` mod A differs from P. A wrong input residue therefore raises `err`, and `err` is 0 in every cycle without a transaction.
- R6: When `fault_en` is 1 with a transaction, bit `fault_bit` of `result` is inverted. `result_chk` is unchanged by the fault. With correct input residues, `err` is raised.
- R7: An input residue written as the all-ones a-bit pattern, after inverse decoding when that is enabled, is accepted as the value zero.
- R8: With INV_CHECK = 1, an input residue is read as the bitwise complement of N mod A, and `result_chk` is delivered as the bitwise complement of P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A transaction is presented this cycle |
| sub_op | input | 1 | 0 = add, 1 = subtract |
| op_x | input | DATA_W | First operand |
| chk_x | input | RES_A | Check residue of op_x |
| op_y | input | DATA_W | Second operand |
| chk_y | input | RES_A | Check residue of op_y |
| fault_en | input | 1 | Invert one bit of the main sum (test) |
| fault_bit | input | $clog2(DATA_W) | Index of the bit to invert |
| out_valid | output | 1 | Result registers updated last cycle |
| result | output | DATA_W | Sum or difference |
| result_chk | output | RES_A | Predicted residue of the result (stored form) |
| err | output | 1 | Residue mismatch detected |

## Verification
The bench builds two instances from the same operand stream, both with DATA_W = 16. The first uses RES_A = 3 (A = 7) with plain residues. The second uses RES_A = 5 (A = 31) with inverted residues. In both, 2^16 mod A is 2, so the wrap correction is a nontrivial constant. The 16-bit sum folds into six slices in the first instance and four in the second, a ragged top slice in both cases, and every bit position can be faulted with a 4-bit index. Carries, borrows, aliased all-ones residues, corrupted residues and injected faults at the low, middle and top bits are all within reach.

// File: rtl/resck_pkg.sv
package resck_pkg;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } resck_op_e;

   // number of a-bit slices needed to cover a w-bit word
   function automatic int slice_count(input int w, input int a);
      return (w + a - 1) / a;
   endfunction

   // 2^w mod (2^a - 1) equals 2^(w mod a); return that exponent
   function automatic int wrap_shift(input int w, input int a);
      return w % a;
   endfunction

endpackage

// File: rtl/resck_eac_add.sv
module resck_eac_add #(
   parameter int AW = 4
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   output logic [AW-1:0] s_o
);
   // modulo 2^AW - 1 addition: carry out re-enters at weight 1
   logic [AW:0] raw;

   assign raw = {1'b0, a_i} + {1'b0, b_i};
   assign s_o = raw[AW-1:0] + AW'(raw[AW]);

endmodule

// File: rtl/resck_main_addsub.sv
module resck_main_addsub #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic              sub_i,
   input  logic              fault_en_i,
   input  logic [IDX_W-1:0]  fault_bit_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              wrap_o
);
   logic [DATA_W-1:0] y_term;
   logic [DATA_W:0]   full;
   logic [DATA_W-1:0] flip;

   assign y_term = sub_i ? ~y_i : y_i;
   assign full   = {1'b0, x_i} + {1'b0, y_term} + (DATA_W+1)'(sub_i);
   // wrap: carry out on add, missing carry (borrow) on subtract
   assign wrap_o = sub_i ? ~full[DATA_W] : full[DATA_W];
   assign flip   = fault_en_i ? (DATA_W'(1) << fault_bit_i) : '0;
   assign sum_o  = full[DATA_W-1:0] ^ flip;

endmodule

// File: rtl/resck_fold.sv
module resck_fold
   import resck_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int AW     = 4
) (
   input  logic [DATA_W-1:0] val_i,
   output logic [AW-1:0]     res_o
);
   localparam int NCH = slice_count(DATA_W, AW);

   logic [NCH*AW-1:0] padded;
   logic [AW-1:0]     acc [NCH];

   assign padded = (NCH*AW)'(val_i);
   assign acc[0] = padded[AW-1:0];

   for (genvar i = 1; i < NCH; i++) begin : g_fold
      resck_eac_add #(.AW(AW)) u_add (
         .a_i (acc[i-1]),
         .b_i (padded[i*AW +: AW]),
         .s_o (acc[i])
      );
   end

   // all-ones is the second spelling of zero
   assign res_o = (&acc[NCH-1]) ? '0 : acc[NCH-1];

endmodule

// File: rtl/resck_check_path.sv
module resck_check_path
   import resck_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int AW        = 4,
   parameter bit INV_CHECK = 1'b0
) (
   input  logic [AW-1:0] chk_x_i,
   input  logic [AW-1:0] chk_y_i,
   input  logic          sub_i,
   input  logic          wrap_i,
   output logic [AW-1:0] pred_o
);
   localparam int          KSH   = wrap_shift(DATA_W, AW);
   localparam logic [AW-1:0] KWRAP = AW'(1) << KSH;

   resck_op_e     op;
   logic [AW-1:0] dx, dy, y_term, w_term, s1, s2;

   assign op = resck_op_e'(sub_i);

   if (INV_CHECK) begin : g_inv
      assign dx = ~chk_x_i;
      assign dy = ~chk_y_i;
   end else begin : g_plain
      assign dx = chk_x_i;
      assign dy = chk_y_i;
   end

   always_comb begin
      y_term = (op == OP_SUB) ? ~dy : dy;
      if (!wrap_i)
         w_term = '0;
      else if (op == OP_SUB)
         w_term = KWRAP;
      else
         w_term = ~KWRAP;
   end

   resck_eac_add #(.AW(AW)) u_opnd (.a_i(dx), .b_i(y_term), .s_o(s1));
   resck_eac_add #(.AW(AW)) u_wrap (.a_i(s1), .b_i(w_term), .s_o(s2));

   assign pred_o = (&s2) ? '0 : s2;

endmodule

// File: rtl/resck_adder.sv
module resck_adder #(
   parameter int DATA_W    = 16,
   parameter int RES_A     = 4,
   parameter bit INV_CHECK = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic                      sub_op,
   input  logic [DATA_W-1:0]         op_x,
   input  logic [RES_A-1:0]          chk_x,
   input  logic [DATA_W-1:0]         op_y,
   input  logic [RES_A-1:0]          chk_y,
   input  logic                      fault_en,
   input  logic [$clog2(DATA_W)-1:0] fault_bit,
   output logic                      out_valid,
   output logic [DATA_W-1:0]         result,
   output logic [RES_A-1:0]          result_chk,
   output logic                      err
);
   localparam int IDX_W = $clog2(DATA_W);

   if (RES_A < 2) begin : g_bad_a
      $error("RES_A must be at least 2");
   end
   if (DATA_W < RES_A) begin : g_bad_w
      $error("DATA_W must not be smaller than RES_A");
   end

   logic [DATA_W-1:0] sum_d;
   logic              wrap_d;
   logic [RES_A-1:0]  fold_d, pred_d, chk_store_d;
   logic              mism_d;

   resck_main_addsub #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_main (
      .x_i         (op_x),
      .y_i         (op_y),
      .sub_i       (sub_op),
      .fault_en_i  (fault_en),
      .fault_bit_i (fault_bit),
      .sum_o       (sum_d),
      .wrap_o      (wrap_d)
   );

   resck_fold #(.DATA_W(DATA_W), .AW(RES_A)) u_fold (
      .val_i (sum_d),
      .res_o (fold_d)
   );

   resck_check_path #(.DATA_W(DATA_W), .AW(RES_A), .INV_CHECK(INV_CHECK)) u_chk (
      .chk_x_i (chk_x),
      .chk_y_i (chk_y),
      .sub_i   (sub_op),
      .wrap_i  (wrap_d),
      .pred_o  (pred_d)
   );

   assign mism_d = (fold_d != pred_d);

   if (INV_CHECK) begin : g_out_inv
      assign chk_store_d = ~pred_d;
   end else begin : g_out_plain
      assign chk_store_d = pred_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         err        <= 1'b0;
         result     <= '0;
         result_chk <= '0;
      end else begin
         out_valid <= in_valid;
         err       <= in_valid & mism_d;
         if (in_valid) begin
            result     <= sum_d;
            result_chk <= chk_store_d;
         end
      end
   end

endmodule

// File: rtl/resck_adder_chk.sv
module resck_adder_chk #(
   parameter int DATA_W    = 16,
   parameter int RES_A     = 4,
   parameter bit INV_CHECK = 1'b0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic                      sub_op,
   input logic [DATA_W-1:0]         op_x,
   input logic [RES_A-1:0]          chk_x,
   input logic [DATA_W-1:0]         op_y,
   input logic [RES_A-1:0]          chk_y,
   input logic                      fault_en,
   input logic [$clog2(DATA_W)-1:0] fault_bit,
   input logic                      out_valid,
   input logic [DATA_W-1:0]         result,
   input logic [RES_A-1:0]          result_chk,
   input logic                      err
);
   localparam longint MODV = (64'd1 << RES_A) - 64'd1;

   function automatic logic [RES_A-1:0] decode(input logic [RES_A-1:0] c);
      return INV_CHECK ? ~c : c;
   endfunction

   logic                      warm, ok_now;
   logic                      p_valid, p_sub, p_fen, p_ok;
   logic [DATA_W-1:0]         p_x, p_y, exp_sum;
   logic [$clog2(DATA_W)-1:0] p_fbit;

   always_comb begin
      ok_now = ((64'(decode(chk_x)) % MODV) == (64'(op_x) % MODV)) &&
               ((64'(decode(chk_y)) % MODV) == (64'(op_y) % MODV));
      exp_sum = p_sub ? (p_x - p_y) : (p_x + p_y);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm    <= 1'b0;
         p_valid <= 1'b0;
         p_sub   <= 1'b0;
         p_fen   <= 1'b0;
         p_ok    <= 1'b0;
         p_x     <= '0;
         p_y     <= '0;
         p_fbit  <= '0;
      end else begin
         warm    <= 1'b1;
         p_valid <= in_valid;
         p_sub   <= sub_op;
         p_fen   <= fault_en;
         p_ok    <= ok_now;
         p_x     <= op_x;
         p_y     <= op_y;
         p_fbit  <= fault_bit;
      end
   end

   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_valid == p_valid));

   assert_err_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> out_valid);

   assert_sum_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && p_valid && !p_fen) |-> (result == exp_sum));

   assert_fault_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && p_valid && p_fen && (int'(p_fbit) < DATA_W)) |->
         ((result ^ exp_sum) == (DATA_W'(1) << p_fbit)));

   assert_fault_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && p_valid && p_fen && p_ok && (int'(p_fbit) < DATA_W)) |-> err);

   assert_no_false_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && p_valid && !p_fen && p_ok) |-> !err);

   assert_canonical_chk_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(&decode(result_chk)));

   assert_chk_matches_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && p_valid && p_ok) |->
         (64'(decode(result_chk)) == (64'(exp_sum) % MODV)));

endmodule

bind resck_adder resck_adder_chk #(
   .DATA_W    (DATA_W),
   .RES_A     (RES_A),
   .INV_CHECK (INV_CHECK)
) u_resck_adder_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .sub_op     (sub_op),
   .op_x       (op_x),
   .chk_x      (chk_x),
   .op_y       (op_y),
   .chk_y      (chk_y),
   .fault_en   (fault_en),
   .fault_bit  (fault_bit),
   .out_valid  (out_valid),
   .result     (result),
   .result_chk (result_chk),
   .err        (err)
);

// File: tb/resck_adder_tb.sv
module resck_adder_tb_top;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0, sub_op = 1'b0, fault_en = 1'b0;
   logic [W-1:0] op_x = '0, op_y = '0;
   logic [2:0]   cx3 = '0, cy3 = '0;
   logic [4:0]   cx5 = '0, cy5 = '0;
   logic [3:0]   fault_bit = '0;

   logic         ov3, err3, ov5, err5;
   logic [W-1:0] res3, res5;
   logic [2:0]   rchk3;
   logic [4:0]   rchk5;

   int n_chk = 0;
   int n_fail = 0;

   // expected state, updated one clock after each drive
   bit      e_valid = 0, e_err3 = 0, e_err5 = 0;
   longint  e_res = 0, e_chk3 = 0, e_chk5 = 0;

   always #10 clk = ~clk;

   resck_adder #(.DATA_W(W), .RES_A(3), .INV_CHECK(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
      .op_x(op_x), .chk_x(cx3), .op_y(op_y), .chk_y(cy3),
      .fault_en(fault_en), .fault_bit(fault_bit),
      .out_valid(ov3), .result(res3), .result_chk(rchk3), .err(err3));

   resck_adder #(.DATA_W(W), .RES_A(5), .INV_CHECK(1'b1)) dut_inv_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
      .op_x(op_x), .chk_x(cx5), .op_y(op_y), .chk_y(cy5),
      .fault_en(fault_en), .fault_bit(fault_bit),
      .out_valid(ov5), .result(res5), .result_chk(rchk5), .err(err5));

   function automatic longint mod_of(int a);
      return (64'd1 << a) - 1;
   endfunction

   // stored residue of a value, plain or inverted
   function automatic longint enc(longint v, int a, bit inv);
      longint m = mod_of(a);
      longint r = v % m;
      return inv ? ((~r) & m) : r;
   endfunction

   function automatic longint pred_res(longint x, longint y, bit sub,
                                       longint cx, longint cy, int a, bit inv);
      longint m = mod_of(a);
      longint dx, dy, k, p;
      dx = (inv ? ((~cx) & m) : cx) % m;
      dy = (inv ? ((~cy) & m) : cy) % m;
      k  = 65536 % m;
      if (sub) p = dx - dy + ((x < y) ? k : 0);
      else     p = dx + dy - ((x + y > 65535) ? k : 0);
      return ((p % m) + 2 * m) % m;
   endfunction

   task automatic check(string tag, string what, longint got, longint exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic compare_all(string tag);
      check(tag, "dut_i out_valid", longint'(ov3), longint'(e_valid));
      check(tag, "dut_inv_i out_valid", longint'(ov5), longint'(e_valid));
      check(tag, "dut_i result", longint'(res3), e_res);
      check(tag, "dut_inv_i result", longint'(res5), e_res);
      check(tag, "dut_i result_chk", longint'(rchk3), e_chk3);
      check(tag, "dut_inv_i result_chk", longint'(rchk5), e_chk5);
      check(tag, "dut_i err", longint'(err3), longint'(e_err3));
      check(tag, "dut_inv_i err", longint'(err5), longint'(e_err5));
   endtask

   // drive at a falling edge, compare after the next rising edge
   task automatic cycle(string tag, bit v, bit sub, longint x, longint y,
                        longint c3x, longint c3y, longint c5x, longint c5y,
                        bit fen, int fb);
      longint r, p3, p5;
      in_valid  = v;
      sub_op    = sub;
      op_x      = W'(x);
      op_y      = W'(y);
      cx3       = 3'(c3x);
      cy3       = 3'(c3y);
      cx5       = 5'(c5x);
      cy5       = 5'(c5y);
      fault_en  = fen;
      fault_bit = 4'(fb);
      @(posedge clk);
      @(negedge clk);
      e_valid = v;
      if (v) begin
         r = (sub ? (x - y) : (x + y)) & 64'hFFFF;
         if (fen) r = r ^ (64'd1 << fb);
         p3 = pred_res(x, y, sub, c3x, c3y, 3, 1'b0);
         p5 = pred_res(x, y, sub, c5x, c5y, 5, 1'b1);
         e_res  = r;
         e_chk3 = p3;
         e_chk5 = (~p5) & 31;
         e_err3 = ((r % 7) != p3);
         e_err5 = ((r % 31) != p5);
      end else begin
         e_err3 = 0;
         e_err5 = 0;
      end
      compare_all(tag);
   endtask

   // transaction with correct residues on both instances
   task automatic good(string tag, bit sub, longint x, longint y, bit fen, int fb);
      cycle(tag, 1'b1, sub, x, y, enc(x, 3, 0), enc(y, 3, 0),
            enc(x, 5, 1), enc(y, 5, 1), fen, fb);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      longint lx = 12345, ly = 777;
      repeat (3) @(negedge clk);
      // R2: reset state
      compare_all("R2");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R2");

      // R1: plain add and subtract
      good("R1", 0, 100, 23, 0, 0);
      good("R1", 1, 500, 7, 0, 0);
      good("R1", 0, 40000, 20000, 0, 0);

      // R4: carries out of the add, borrows on subtract
      good("R4", 0, 16'hFFFF, 3, 0, 0);
      good("R4", 0, 16'hF000, 16'h2000, 0, 0);
      good("R4", 1, 5, 9, 0, 0);
      good("R4", 1, 0, 1, 0, 0);
      good("R4", 0, 16'hFFFF, 16'hFFFF, 0, 0);

      // R2: idle cycles hold result, no error even with fault_en
      cycle("R2", 0, 0, 1, 2, 0, 0, 0, 0, 0, 0);
      cycle("R2", 0, 1, 99, 3, 5, 5, 5, 5, 1, 4);

      // R3 / R8: mixed stream, back to back
      for (int i = 0; i < 24; i++) begin
         lx = (lx * 1103 + 12345) & 64'hFFFF;
         ly = (ly * 2111 + 4321) & 64'hFFFF;
         good((i % 2) ? "R8" : "R3", i % 2, lx, ly, 0, 0);
      end

      // R7: all-ones residue spelling of zero on input
      cycle("R7", 1, 0, 14, 3, 7, enc(3, 3, 0), enc(14, 5, 1), enc(3, 5, 1), 0, 0);
      cycle("R7", 1, 1, 62, 5, enc(62, 3, 0), enc(5, 3, 0), 0, enc(5, 5, 1), 0, 0);

      // R6: injected single-bit faults
      good("R6", 0, 1000, 2000, 1, 0);
      good("R6", 1, 9000, 123, 1, 7);
      good("R6", 0, 16'h7FFF, 1, 1, 15);
      good("R6", 1, 3, 16'h8000, 1, 11);

      // R5: corrupted operand residue is flagged
      cycle("R5", 1, 0, 300, 45, (300 % 7 + 1) % 7, enc(45, 3, 0),
            enc(300, 5, 1), enc(45, 5, 1), 0, 0);
      cycle("R5", 1, 1, 300, 45, enc(300, 3, 0), enc(45, 3, 0),
            enc(300, 5, 1), enc(46, 5, 1), 0, 0);
      cycle("R5", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule